// File: doc/BRIEF.md
# Sharer Group Multicast Controller

This block lives in one slice of a shared last-level cache. Software declares groups of cores that read the same data. Each core in a group sends a configuration request that carries a group identifier and the declared member count. Once the last expected member has checked in, the slice sends one configuration response to the whole group. That response names the leader core and the member mask.

After configuration, a prefetch from the leader that carries the group's identifier is answered with one multicast data response to every member. Any other prefetch, and any explicit unicast request, is answered only to the core that sent it. Followers report timeouts to the slice. When one group's timeout reports reach a programmable limit, the leader role moves to the follower that reported last, and all members are told.

A core that switches out sends a deallocation message. The slice then removes that core from every group. If the core was a leader, the lowest-numbered remaining member takes over. When a group loses its last member, its table slot is freed. A core that comes back must configure again.

Every response leaves through a single registered response port, one cycle after the request that caused it.

Top module: `sgm_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rsp_valid` is 0 and the group table is empty. A prefetch issued then is answered as a unicast.
- R2: While a group has fewer members than its declared count, a configuration request from a new member produces no response. A prefetch tagged with that group is answered as a unicast (kind 4) to the requester only.
- R3: The configuration request that brings a group's member count up to its declared count (a count of 0 is taken as 1) produces a response of kind 1. That response carries the full member mask, and its leader is the first core that configured the group.
- R4: On an active group, a prefetch (op 1) from the leader produces a response of kind 3. Its mask is the group's member mask and its leader field is the leader.
- R5: A prefetch from a non-leader, a prefetch with an unknown group, or an explicit unicast request (op 4) produces a response of kind 4. Its mask has only the requester's bit set.
- R6: A configuration request (op 0) for an unknown group while every table slot is in use produces a response of kind 2, addressed only to the requester. The table does not change.
- R7: Timeout reports (op 2) from a follower of an active group are counted per group. The report that brings the count up to `tmo_limit` produces a response of kind 5 to the member mask, and that response names the reporter as the new leader. The count then restarts from zero.
- R8: A timeout report from the leader, from a non-member, or for a pending or unknown group produces no response and does not change any count.
- R9: A deallocation (op 3) clears the core's bit in every group and produces no response. A leader that leaves is replaced by the lowest-numbered remaining member. A group left with no members frees its slot.
- R10: A configuration request from a core that is not a member of an already active group adds that core to the group. It produces a response of kind 1 carrying the enlarged mask and the current leader.
- R11: A response appears exactly one cycle after the request that caused it. No response appears in a cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 configure, 1 prefetch, 2 timeout, 3 deallocate, 4 unicast |
| req_core | input | 6 | Requesting core |
| req_gid | input | 6 | Group identifier |
| req_need | input | 7 | Declared member count (configure only) |
| tmo_limit | input | 8 | Timeout reports that move the leader |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 3 | 1 join, 2 reject, 3 multicast data, 4 unicast data, 5 leader change |
| rsp_gid | output | 6 | Group identifier of the response |
| rsp_mask | output | 64 | Destination cores |
| rsp_leader | output | 6 | Leader named in the response |

## Verification
On every cycle, the assertions check several properties at the response port. Each response follows a request. Unicast and reject responses reach exactly the requester. A multicast names its requester as leader and includes it in the mask. A leader change follows a timeout from the new leader. A join response includes the core that asked. The bench's scenarios are what show the rest: whether the mask holds exactly the right members, when a pending group becomes active, that the timeout count restarts after a switch, that ignored timeouts leave the count alone, that the table fills and then frees on deallocation, and that the leader falls back to the lowest member.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  typedef enum logic [2:0] {
    OP_CFG  = 3'd0,
    OP_PREF = 3'd1,
    OP_TMO  = 3'd2,
    OP_DROP = 3'd3,
    OP_UNI  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    RS_NONE   = 3'd0,
    RS_JOIN   = 3'd1,
    RS_REJECT = 3'd2,
    RS_MCAST  = 3'd3,
    RS_UNI    = 3'd4,
    RS_SWAP   = 3'd5
  } rsp_e;
endpackage

// File: rtl/sgm_prienc.sv
// Lowest-index set bit finder.
module sgm_prienc #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgm_popcnt.sv
// Population count of a member mask.
module sgm_popcnt #(
  parameter int W  = 64,
  parameter int OW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [OW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + OW'(vec[i]);
  end
endmodule

// File: rtl/sgm_match.sv
// Group-identifier lookup over the table plus free-slot search.
module sgm_match #(
  parameter int NG = 4,
  parameter int GW = 6,
  parameter int IW = $clog2(NG)
) (
  input  logic [NG-1:0]    slot_used,
  input  logic [NG*GW-1:0] slot_gid,
  input  logic [GW-1:0]    key,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic             free_any,
  output logic [IW-1:0]    free_idx
);
  logic [NG-1:0] eq;

  for (genvar g = 0; g < NG; g++) begin : g_cmp
    assign eq[g] = slot_used[g] && (slot_gid[g*GW +: GW] == key);
  end

  sgm_prienc #(.W(NG), .IW(IW)) u_hit (
    .vec(eq), .idx(hit_idx), .any(hit)
  );

  sgm_prienc #(.W(NG), .IW(IW)) u_free (
    .vec(~slot_used), .idx(free_idx), .any(free_any)
  );
endmodule

// File: rtl/sgm_ctrl.sv
module sgm_ctrl #(
  parameter int NCORE = 64,
  parameter int NGRP  = 4,
  parameter int GW    = 6,
  parameter int TW    = 8,
  localparam int CW   = $clog2(NCORE),
  localparam int IW   = $clog2(NGRP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [CW-1:0]     req_core,
  input  logic [GW-1:0]     req_gid,
  input  logic [CW:0]       req_need,
  input  logic [TW-1:0]     tmo_limit,
  output logic              rsp_valid,
  output logic [2:0]        rsp_kind,
  output logic [GW-1:0]     rsp_gid,
  output logic [NCORE-1:0]  rsp_mask,
  output logic [CW-1:0]     rsp_leader
);
  import sgm_pkg::*;

  // group table state
  logic             t_val  [NGRP];
  logic             t_act  [NGRP];
  logic [GW-1:0]    t_gid  [NGRP];
  logic [NCORE-1:0] t_mask [NGRP];
  logic [CW-1:0]    t_lead [NGRP];
  logic [CW:0]      t_need [NGRP];
  logic [TW-1:0]    t_cnt  [NGRP];

  logic             n_val  [NGRP];
  logic             n_act  [NGRP];
  logic [GW-1:0]    n_gid  [NGRP];
  logic [NCORE-1:0] n_mask [NGRP];
  logic [CW-1:0]    n_lead [NGRP];
  logic [CW:0]      n_need [NGRP];
  logic [TW-1:0]    n_cnt  [NGRP];

  logic [2:0]       r_kind;
  logic [NCORE-1:0] r_mask;
  logic [CW-1:0]    r_lead;

  logic [NGRP-1:0]    used_vec;
  logic [NGRP*GW-1:0] gid_flat;
  logic               hit, free_any;
  logic [IW-1:0]      h, free_idx;

  for (genvar g = 0; g < NGRP; g++) begin : g_flat
    assign used_vec[g]            = t_val[g];
    assign gid_flat[g*GW +: GW]   = t_gid[g];
  end

  sgm_match #(.NG(NGRP), .GW(GW), .IW(IW)) u_match (
    .slot_used(used_vec), .slot_gid(gid_flat), .key(req_gid),
    .hit(hit), .hit_idx(h), .free_any(free_any), .free_idx(free_idx)
  );

  logic [NCORE-1:0] core_bit, sel_mask, add_mask;
  logic [CW:0]      add_cnt;
  logic             is_mem;

  assign core_bit = NCORE'(1) << req_core;
  assign sel_mask = t_mask[h];
  assign add_mask = sel_mask | core_bit;
  assign is_mem   = |(sel_mask & core_bit);

  sgm_popcnt #(.W(NCORE), .OW(CW + 1)) u_pop (.vec(add_mask), .cnt(add_cnt));

  // per-slot replacement leader if the departing core held the role
  logic [CW-1:0] low_idx [NGRP];
  logic          low_any [NGRP];
  for (genvar g = 0; g < NGRP; g++) begin : g_low
    sgm_prienc #(.W(NCORE), .IW(CW)) u_low (
      .vec(t_mask[g] & ~core_bit), .idx(low_idx[g]), .any(low_any[g])
    );
  end

  logic tmo_due;
  assign tmo_due = ({1'b0, t_cnt[h]} + 1'b1) >= {1'b0, tmo_limit};

  // next-state logic
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      n_val[g]  = t_val[g];
      n_act[g]  = t_act[g];
      n_gid[g]  = t_gid[g];
      n_mask[g] = t_mask[g];
      n_lead[g] = t_lead[g];
      n_need[g] = t_need[g];
      n_cnt[g]  = t_cnt[g];
    end
    r_kind = RS_NONE;
    r_mask = '0;
    r_lead = '0;

    if (req_valid) begin
      case (req_op)
        OP_CFG: begin
          if (hit) begin
            if (!is_mem) begin
              n_mask[h] = add_mask;
              if (t_act[h] || (add_cnt >= t_need[h])) begin
                n_act[h] = 1'b1;
                r_kind   = RS_JOIN;
                r_mask   = add_mask;
                r_lead   = t_lead[h];
              end
            end else if (t_act[h]) begin
              r_kind = RS_JOIN;
              r_mask = sel_mask;
              r_lead = t_lead[h];
            end
          end else if (free_any) begin
            n_val[free_idx]  = 1'b1;
            n_act[free_idx]  = (req_need <= (CW+1)'(1));
            n_gid[free_idx]  = req_gid;
            n_mask[free_idx] = core_bit;
            n_lead[free_idx] = req_core;
            n_need[free_idx] = req_need;
            n_cnt[free_idx]  = '0;
            if (req_need <= (CW+1)'(1)) begin
              r_kind = RS_JOIN;
              r_mask = core_bit;
              r_lead = req_core;
            end
          end else begin
            r_kind = RS_REJECT;
            r_mask = core_bit;
            r_lead = req_core;
          end
        end
        OP_PREF: begin
          if (hit && t_act[h] && (t_lead[h] == req_core)) begin
            r_kind = RS_MCAST;
            r_mask = sel_mask;
            r_lead = t_lead[h];
          end else begin
            r_kind = RS_UNI;
            r_mask = core_bit;
            r_lead = req_core;
          end
        end
        OP_UNI: begin
          r_kind = RS_UNI;
          r_mask = core_bit;
          r_lead = req_core;
        end
        OP_TMO: begin
          if (hit && t_act[h] && is_mem && (t_lead[h] != req_core)) begin
            if (tmo_due) begin
              n_lead[h] = req_core;
              n_cnt[h]  = '0;
              r_kind    = RS_SWAP;
              r_mask    = sel_mask;
              r_lead    = req_core;
            end else begin
              n_cnt[h] = t_cnt[h] + 1'b1;
            end
          end
        end
        OP_DROP: begin
          for (int g = 0; g < NGRP; g++) begin
            if (t_val[g] && t_mask[g][req_core]) begin
              n_mask[g] = t_mask[g] & ~core_bit;
              if (!low_any[g]) begin
                n_val[g] = 1'b0;
                n_act[g] = 1'b0;
              end else if (t_lead[g] == req_core) begin
                n_lead[g] = low_idx[g];
                n_cnt[g]  = '0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  // table registers, enabled by an incoming request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) begin
        t_val[g]  <= 1'b0;
        t_act[g]  <= 1'b0;
        t_gid[g]  <= '0;
        t_mask[g] <= '0;
        t_lead[g] <= '0;
        t_need[g] <= '0;
        t_cnt[g]  <= '0;
      end
    end else if (req_valid) begin
      for (int g = 0; g < NGRP; g++) begin
        t_val[g]  <= n_val[g];
        t_act[g]  <= n_act[g];
        t_gid[g]  <= n_gid[g];
        t_mask[g] <= n_mask[g];
        t_lead[g] <= n_lead[g];
        t_need[g] <= n_need[g];
        t_cnt[g]  <= n_cnt[g];
      end
    end
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_kind   <= RS_NONE;
      rsp_gid    <= '0;
      rsp_mask   <= '0;
      rsp_leader <= '0;
    end else begin
      rsp_kind   <= r_kind;
      rsp_gid    <= req_gid;
      rsp_mask   <= r_mask;
      rsp_leader <= r_lead;
    end
  end

  assign rsp_valid = (rsp_kind != RS_NONE);
endmodule

// File: rtl/sgm_ctrl_chk.sv
module sgm_ctrl_chk #(
  parameter int NCORE = 64,
  parameter int CW    = $clog2(NCORE)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [CW-1:0]    req_core,
  input logic             rsp_valid,
  input logic [2:0]       rsp_kind,
  input logic [NCORE-1:0] rsp_mask,
  input logic [CW-1:0]    rsp_leader
);
  import sgm_pkg::*;

  // R11: a response always follows a request
  a_r11_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R5: unicast reaches exactly the requester
  a_r5_uni_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind == RS_UNI) |-> ($countones(rsp_mask) == 1 && rsp_mask[$past(req_core)]));

  // R6: reject goes only to the configuring core
  a_r6_reject_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind == RS_REJECT) |-> ($countones(rsp_mask) == 1 && rsp_mask[$past(req_core)]
                                 && $past(req_op) == OP_CFG));

  // R4: multicast comes from the leader and includes it
  a_r4_mcast_leader: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind == RS_MCAST) |-> (rsp_mask[rsp_leader] && rsp_leader == $past(req_core)
                                && $past(req_op) == OP_PREF));

  // R7: leader change follows a timeout from the new leader
  a_r7_swap_reporter: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind == RS_SWAP) |-> (rsp_leader == $past(req_core) && $past(req_op) == OP_TMO
                               && rsp_mask[rsp_leader]));

  // R3: join response includes the configuring core
  a_r3_join_member: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind == RS_JOIN) |-> (rsp_mask[$past(req_core)] && rsp_mask[rsp_leader]));
endmodule

bind sgm_ctrl sgm_ctrl_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_core(req_core), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
  .rsp_mask(rsp_mask), .rsp_leader(rsp_leader)
);

// File: tb/sim_sgm_ctrl.sv
module sim_sgm_ctrl;
  localparam int NC = 64;
  localparam int NG = 4;
  localparam int GW = 6;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [5:0]    req_core = '0;
  logic [GW-1:0] req_gid = '0;
  logic [6:0]    req_need = '0;
  logic [TW-1:0] tmo_limit = 8'd3;
  logic          rsp_valid;
  logic [2:0]    rsp_kind;
  logic [GW-1:0] rsp_gid;
  logic [NC-1:0] rsp_mask;
  logic [5:0]    rsp_leader;

  sgm_ctrl #(.NCORE(NC), .NGRP(NG), .GW(GW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_core(req_core), .req_gid(req_gid), .req_need(req_need),
    .tmo_limit(tmo_limit), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_gid(rsp_gid), .rsp_mask(rsp_mask), .rsp_leader(rsp_leader)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference model
  bit          mv [NG];
  bit          ma [NG];
  int          mg [NG];
  int          ml [NG];
  int          mn [NG];
  int          mc [NG];
  bit [63:0]   mm [NG];
  int          ek, el, eg;
  bit [63:0]   em;

  function automatic int lowest(bit [63:0] m);
    for (int i = 0; i < 64; i++) if (m[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        mv[g] = 0; ma[g] = 0; mm[g] = '0; mc[g] = 0;
      end
      ek = 0; em = '0; el = 0; eg = 0;
    end else begin
      int hx, fx, c;
      bit [63:0] cb;
      ek = 0; em = '0; el = 0; eg = int'(req_gid);
      c  = int'(req_core);
      cb = 64'd1 << c;
      hx = -1; fx = -1;
      for (int g = NG - 1; g >= 0; g--) begin
        if (mv[g] && mg[g] == int'(req_gid)) hx = g;
        if (!mv[g]) fx = g;
      end
      if (req_valid) begin
        case (int'(req_op))
          0: begin
            if (hx >= 0) begin
              if (mm[hx][c] == 0) begin
                mm[hx] |= cb;
                if (ma[hx] || $countones(mm[hx]) >= mn[hx]) begin
                  ma[hx] = 1; ek = 1; em = mm[hx]; el = ml[hx];
                end
              end else if (ma[hx]) begin
                ek = 1; em = mm[hx]; el = ml[hx];
              end
            end else if (fx >= 0) begin
              mv[fx] = 1; mg[fx] = int'(req_gid); mm[fx] = cb; ml[fx] = c;
              mn[fx] = int'(req_need); mc[fx] = 0; ma[fx] = (req_need <= 1);
              if (req_need <= 1) begin ek = 1; em = cb; el = c; end
            end else begin
              ek = 2; em = cb; el = c;
            end
          end
          1: begin
            if (hx >= 0 && ma[hx] && ml[hx] == c) begin
              ek = 3; em = mm[hx]; el = c;
            end else begin
              ek = 4; em = cb; el = c;
            end
          end
          4: begin ek = 4; em = cb; el = c; end
          2: begin
            if (hx >= 0 && ma[hx] && mm[hx][c] && ml[hx] != c) begin
              if (mc[hx] + 1 >= int'(tmo_limit)) begin
                ml[hx] = c; mc[hx] = 0; ek = 5; em = mm[hx]; el = c;
              end else mc[hx]++;
            end
          end
          3: begin
            for (int g = 0; g < NG; g++) begin
              if (mv[g] && mm[g][c]) begin
                mm[g] &= ~cb;
                if (mm[g] == 0) begin mv[g] = 0; ma[g] = 0; end
                else if (ml[g] == c) begin ml[g] = lowest(mm[g]); mc[g] = 0; end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (ek == 0) begin
        if (rsp_valid !== 1'b0) begin
          n_bad++;
          $display("FAIL %s: rsp_valid got %0b exp 0 (kind %0d)", tag, rsp_valid, rsp_kind);
        end
      end else if (rsp_valid !== 1'b1 || int'(rsp_kind) != ek || rsp_mask !== em ||
                   int'(rsp_leader) != el || int'(rsp_gid) != eg) begin
        n_bad++;
        $display("FAIL %s: kind/mask/leader/gid got %0d/%h/%0d/%0d exp %0d/%h/%0d/%0d",
                 tag, rsp_kind, rsp_mask, rsp_leader, rsp_gid, ek, em, el, eg);
      end
    end
  end

  task automatic put(string t, int op, int core, int gid, int need = 0);
    tag       = t;
    req_valid = 1'b1;
    req_op    = 3'(op);
    req_core  = 6'(core);
    req_gid   = GW'(gid);
    req_need  = 7'(need);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(string t, int n);
    tag = t;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rsp_valid in reset got %0b exp 0", rsp_valid);
    end
    rst_n = 1'b1;
    idle("R1", 2);
    put("R1", 1, 5, 1);
    // configuration of group 1 with three members
    put("R2", 0, 2, 1, 3);
    put("R2", 0, 7, 1, 3);
    put("R2", 1, 2, 1);
    put("R3", 0, 40, 1, 3);
    idle("R11", 2);
    put("R4", 1, 2, 1);
    put("R5", 1, 7, 1);
    put("R5", 4, 40, 1);
    put("R5", 1, 9, 33);
    // ignored timeouts, then switching
    put("R8", 2, 2, 1);
    put("R8", 2, 9, 1);
    put("R8", 2, 7, 33);
    put("R7", 2, 7, 1);
    put("R7", 2, 40, 1);
    put("R7", 2, 7, 1);
    put("R4", 1, 7, 1);
    put("R7", 2, 40, 1);
    put("R7", 2, 2, 1);
    put("R7", 2, 40, 1);
    // fill the table
    put("R6", 0, 10, 2, 1);
    put("R6", 0, 11, 3, 1);
    put("R6", 0, 12, 4, 0);
    put("R6", 0, 13, 5, 1);
    put("R6", 1, 13, 5);
    // deallocation
    put("R9", 3, 40, 0);
    put("R9", 1, 2, 1);
    put("R9", 3, 10, 0);
    put("R9", 0, 13, 5, 1);
    // rejoin
    put("R10", 0, 40, 1);
    put("R10", 1, 2, 1);
    // mixed traffic over a small core and group range
    for (int i = 0; i < 600; i++) begin
      tmo_limit = TW'($urandom_range(0, 4));
      put("R11", int'($urandom_range(0, 4)), int'($urandom_range(0, 7)),
          int'($urandom_range(0, 6)), int'($urandom_range(0, 4)));
      if ($urandom_range(0, 3) == 0) idle("R11", 1);
    end
    idle("R11", 3);
    finish_run();
  end
endmodule